// File: doc/BRIEF.md
# DMA Channel Control Register with NMI Suspend

This block holds the 8-bit control register of one DMA channel and derives the channel-enable logic from it. Software reads the register through a read strobe and writes it through a write strobe. The register selects the activation source, the role of the block area in block transfer mode and the step direction of the destination address. The channel runs only while the master enable in this register and a separate channel enable from a companion register are both set.

The master enable is guarded against accidental setting. A write of 1 lands only after software has read the register and seen the bit at 0. A non-maskable interrupt pulse forces the bit to 0, which stops the channel so the processor can have the bus. The channel stays stopped until software goes through the read-then-write sequence again. Entering standby clears the whole register.

The block also holds the destination address register. It can be loaded directly, and on every transfer-done strobe it moves up, moves down or holds, by one or two bytes.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, and in any cycle that `standby` is high, the control register reads 0x00 and any pending arming read is discarded.
- R2: `chan_active` is 1 exactly when register bit 7 (master enable) is 1 and `chan_en` is 1.
- R3: A cycle with `nmi` high leaves bit 7 at 0 and discards any arming read, even when a write of 1 to bit 7 arrives in the same cycle. Bits 6:0 of that write still land.
- R4: A write with bit 7 = 1 sets the master enable only if a read was made while bit 7 was 0, with no write, `nmi` or `standby` since that read. Any write consumes the arming read. Otherwise the bit keeps its old value.
- R5: A write with bit 7 = 0 clears the master enable at once, with no prior read.
- R6: Bit 6 stores whatever value was written and reads back unchanged.
- R7: Bits 5:4 set the destination step: 10 is increment (`dst_inc`=1), 11 is decrement (`dst_dec`=1), and 00 or 01 is fixed (both outputs 0).
- R8: On `xfer_done` the destination address moves by 1, or by 2 when `unit_wide` is 1, in the direction set by R7, wrapping modulo 2^24. `addr_load` loads `addr_din` and takes priority over `xfer_done`.
- R9: `blk_is_dst` follows bit 3: 1 means the block area is the destination, 0 means it is the source.
- R10: `act_src` follows bits 2:0, the activation source code.

Writes to bits 6:0 always take effect and do not depend on the arming read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | High while in standby; clears the register |
| nmi | input | 1 | Non-maskable interrupt pulse |
| rd_stb | input | 1 | CPU read strobe for the control register |
| wr_stb | input | 1 | CPU write strobe for the control register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| chan_en | input | 1 | Channel enable bit from the companion register |
| unit_wide | input | 1 | Transfer unit: 0 is one byte, 1 is two bytes |
| xfer_done | input | 1 | One unit has been transferred |
| addr_load | input | 1 | Load the destination address |
| addr_din | input | 24 | Destination address load value |
| chan_active | output | 1 | Channel enabled |
| act_src | output | 3 | Activation source select |
| blk_is_dst | output | 1 | Block area is the destination side |
| dst_inc | output | 1 | Destination address steps up |
| dst_dec | output | 1 | Destination address steps down |
| dst_addr | output | 24 | Destination address register |

## Verification
Some properties are checked on every cycle:
- the master enable never rises without a pending arming read;
- `nmi` and `standby` clear what they must one cycle later;
- a write of 0 clears the enable;
- each destination step moves the address by the signed unit and fixed mode holds it.

Only the bench scenarios show the rest:
- the full arming sequence, including a rejected write of 1 and the re-arm needed after a suspension;
- the exact bits read back from the register;
- the field decodes;
- address wrap-around.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
   localparam int CTL_W   = 8;
   localparam int MEN_BIT = 7;
   localparam int RSV_BIT = 6;
   localparam int STP_HI  = 5;
   localparam int STP_LO  = 4;
   localparam int BLK_BIT = 3;
   localparam int SRC_HI  = 2;
   localparam int SRC_W   = SRC_HI + 1;

   typedef enum logic [1:0] {
      STEP_FIX = 2'd0,
      STEP_INC = 2'd1,
      STEP_DEC = 2'd2
   } step_e;

   function automatic step_e decode_step(input logic [1:0] code);
      case (code)
         2'b10:   return STEP_INC;
         2'b11:   return STEP_DEC;
         default: return STEP_FIX;
      endcase
   endfunction
endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
   import dma_ctl_pkg::*;
#(
   parameter bit ARM_REQUIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby,
   input  logic             nmi,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] ctl_q
);
   logic             arm_q, arm_d, set_ok;
   logic [CTL_W-1:0] ctl_d;

   generate
      if (ARM_REQUIRED) begin : g_guarded
         assign set_ok = arm_q;
      end else begin : g_plain
         assign set_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      ctl_d = ctl_q;
      arm_d = arm_q;
      if (rd_stb && !ctl_q[MEN_BIT]) arm_d = 1'b1;
      if (wr_stb) begin
         arm_d             = 1'b0;
         ctl_d[CTL_W-2:0]  = wr_data[CTL_W-2:0];
         ctl_d[MEN_BIT]    = wr_data[MEN_BIT] ? (ctl_q[MEN_BIT] | set_ok) : 1'b0;
      end
      if (nmi) begin
         ctl_d[MEN_BIT] = 1'b0;
         arm_d          = 1'b0;
      end
      if (standby) begin
         ctl_d = '0;
         arm_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         arm_q <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         arm_q <= arm_d;
      end
   end

   generate
      if (ARM_REQUIRED) begin : g_arm_chk
         // R4: enable rises only on a pending arming read
         p_set_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_q[MEN_BIT]) |-> ($past(arm_q) && $past(wr_stb)));
      end
   endgenerate

   p_nmi_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> !ctl_q[MEN_BIT]);

   p_standby_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (ctl_q == '0));

   p_write_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_data[MEN_BIT]) |=> !ctl_q[MEN_BIT]);

   p_reserved_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !standby) |=> (ctl_q[RSV_BIT] == $past(wr_data[RSV_BIT])));
endmodule

// File: rtl/dma_dst_addr.sv
module dma_dst_addr
   import dma_ctl_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int NARROW_SZ = 1,
   parameter int WIDE_SZ   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_e             step,
   input  logic              unit_wide,
   input  logic              xfer_done,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_din,
   output logic [ADDR_W-1:0] addr_q
);
   localparam logic [ADDR_W-1:0] NARROW_V = ADDR_W'(NARROW_SZ);
   localparam logic [ADDR_W-1:0] WIDE_V   = ADDR_W'(WIDE_SZ);

   logic [ADDR_W-1:0] unit;
   assign unit = unit_wide ? WIDE_V : NARROW_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_load) begin
         addr_q <= addr_din;
      end else if (xfer_done) begin
         case (step)
            STEP_INC: addr_q <= addr_q + unit;
            STEP_DEC: addr_q <= addr_q - unit;
            default:  addr_q <= addr_q;
         endcase
      end
   end

   p_step_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !addr_load && step == STEP_INC) |=>
      (addr_q == $past(addr_q) + (($past(unit_wide)) ? WIDE_V : NARROW_V)));

   p_step_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !addr_load && step == STEP_DEC) |=>
      (addr_q == $past(addr_q) - (($past(unit_wide)) ? WIDE_V : NARROW_V)));

   p_fixed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_load && step == STEP_FIX) |=> $stable(addr_q));

   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load |=> (addr_q == $past(addr_din)));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_ctl_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int NARROW_SZ    = 1,
   parameter int WIDE_SZ      = 2,
   parameter bit ARM_REQUIRED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              nmi,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  logic              chan_en,
   input  logic              unit_wide,
   input  logic              xfer_done,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_din,
   output logic              chan_active,
   output logic [2:0]        act_src,
   output logic              blk_is_dst,
   output logic              dst_inc,
   output logic              dst_dec,
   output logic [ADDR_W-1:0] dst_addr
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("dma_chan_ctrl: ADDR_W must lie in 8..32");
      end
      if (NARROW_SZ < 1 || WIDE_SZ < NARROW_SZ) begin : g_bad_unit
         $error("dma_chan_ctrl: unit sizes must be positive and ordered");
      end
   endgenerate

   logic [CTL_W-1:0] ctl;
   step_e            step;

   dma_ctl_reg #(.ARM_REQUIRED(ARM_REQUIRED)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .standby (standby),
      .nmi     (nmi),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .ctl_q   (ctl)
   );

   assign step = decode_step(ctl[STP_HI:STP_LO]);

   dma_dst_addr #(
      .ADDR_W    (ADDR_W),
      .NARROW_SZ (NARROW_SZ),
      .WIDE_SZ   (WIDE_SZ)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .unit_wide (unit_wide),
      .xfer_done (xfer_done),
      .addr_load (addr_load),
      .addr_din  (addr_din),
      .addr_q    (dst_addr)
   );

   assign rd_data     = ctl;
   assign chan_active = ctl[MEN_BIT] & chan_en;
   assign act_src     = ctl[SRC_HI:0];
   assign blk_is_dst  = ctl[BLK_BIT];
   assign dst_inc     = (step == STEP_INC);
   assign dst_dec     = (step == STEP_DEC);

   p_nmi_suspends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> !chan_active);

   p_no_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> !chan_active);
endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0, nmi = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        chan_en = 1'b0, unit_wide = 1'b0, xfer_done = 1'b0, addr_load = 1'b0;
   logic [23:0] addr_din = '0;
   logic        chan_active, blk_is_dst, dst_inc, dst_dec;
   logic [2:0]  act_src;
   logic [23:0] dst_addr;
   int          errors = 0, checks = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   dma_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .nmi(nmi),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
      .chan_en(chan_en), .unit_wide(unit_wide), .xfer_done(xfer_done),
      .addr_load(addr_load), .addr_din(addr_din), .chan_active(chan_active),
      .act_src(act_src), .blk_is_dst(blk_is_dst), .dst_inc(dst_inc),
      .dst_dec(dst_dec), .dst_addr(dst_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d, input logic with_nmi = 1'b0);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = d; nmi = with_nmi;
      @(negedge clk);
      wr_stb = 1'b0; nmi = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic pulse_nmi();
      @(negedge clk); nmi = 1'b1;
      @(negedge clk); nmi = 1'b0;
   endtask

   task automatic pulse_standby();
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
   endtask

   task automatic do_done(input logic wide);
      @(negedge clk); xfer_done = 1'b1; unit_wide = wide;
      @(negedge clk); xfer_done = 1'b0;
   endtask

   task automatic do_load(input logic [23:0] a);
      @(negedge clk); addr_load = 1'b1; addr_din = a;
      @(negedge clk); addr_load = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset value", rd_data, 8'h00);
      chk("R2 idle after reset", chan_active, 1'b0);
      chk("R8 address after reset", dst_addr, 24'h0);
   endtask

   task automatic t_arming();
      chan_en = 1'b1;
      do_write(8'h80);
      chk("R4 write 1 without read", rd_data, 8'h00);
      chk("R2 not active", chan_active, 1'b0);
      do_read();
      do_write(8'h80);
      chk("R4 armed write sets enable", rd_data, 8'h80);
      chk("R2 active with both enables", chan_active, 1'b1);
      chan_en = 1'b0;
      #1 chk("R2 companion enable low", chan_active, 1'b0);
      chan_en = 1'b1;
      do_write(8'h00);
      chk("R5 write 0 clears at once", rd_data, 8'h00);
      do_write(8'hC5);
      chk("R4 arming consumed by earlier write", rd_data, 8'h45);
      do_read();
      do_write(8'hC5);
      chk("R4 re-armed write", rd_data, 8'hC5);
      chk("R10 activation source", act_src, 3'd5);
      chk("R6 reserved bit set", rd_data[6], 1'b1);
      do_write(8'h80);
      chk("R6 reserved bit cleared, enable held", rd_data, 8'h80);
      do_read();
      do_write(8'h00);
      do_write(8'h80);
      chk("R4 read while enabled does not arm", rd_data, 8'h00);
   endtask

   task automatic t_nmi();
      do_read();
      do_write(8'h80);
      chk("R2 active before NMI", chan_active, 1'b1);
      pulse_nmi();
      chk("R3 NMI clears enable", rd_data, 8'h00);
      chk("R3 channel suspended", chan_active, 1'b0);
      do_write(8'h80);
      chk("R3 no resume without re-arm", chan_active, 1'b0);
      do_read();
      do_write(8'h80);
      chk("R3 resume after re-arm", chan_active, 1'b1);
      do_write(8'h00);
      do_read();
      do_write(8'h8A, 1'b1);
      chk("R3 NMI beats same-cycle write", rd_data, 8'h0A);
      do_read();
      pulse_nmi();
      do_write(8'h80);
      chk("R3 NMI discards arming read", rd_data, 8'h00);
   endtask

   task automatic t_standby();
      do_read();
      do_write(8'hFF);
      chk("R4 set all bits", rd_data, 8'hFF);
      pulse_standby();
      chk("R1 standby clears register", rd_data, 8'h00);
      do_read();
      pulse_standby();
      do_write(8'h80);
      chk("R1 standby discards arming read", rd_data, 8'h00);
   endtask

   task automatic t_fields();
      do_write(8'h08);
      chk("R9 block area is destination", blk_is_dst, 1'b1);
      do_write(8'h03);
      chk("R9 block area is source", blk_is_dst, 1'b0);
      chk("R10 source code 3", act_src, 3'd3);
      do_write(8'h20);
      chk("R7 code 10 increments", {dst_inc, dst_dec}, 2'b10);
      do_write(8'h30);
      chk("R7 code 11 decrements", {dst_inc, dst_dec}, 2'b01);
      do_write(8'h10);
      chk("R7 code 01 fixed", {dst_inc, dst_dec}, 2'b00);
      do_write(8'h00);
      chk("R7 code 00 fixed", {dst_inc, dst_dec}, 2'b00);
   endtask

   task automatic t_addr();
      do_load(24'h000100);
      chk("R8 load", dst_addr, 24'h000100);
      do_write(8'h20);
      do_done(1'b0);
      chk("R8 increment by 1", dst_addr, 24'h000101);
      do_done(1'b1);
      chk("R8 increment by 2", dst_addr, 24'h000103);
      do_write(8'h30);
      do_done(1'b1);
      chk("R8 decrement by 2", dst_addr, 24'h000101);
      do_done(1'b0);
      chk("R8 decrement by 1", dst_addr, 24'h000100);
      do_write(8'h10);
      do_done(1'b1);
      chk("R7 fixed 01 holds", dst_addr, 24'h000100);
      do_write(8'h00);
      do_done(1'b0);
      chk("R7 fixed 00 holds", dst_addr, 24'h000100);
      do_load(24'hFFFFFF);
      do_write(8'h20);
      do_done(1'b0);
      chk("R8 wrap upward", dst_addr, 24'h000000);
      do_write(8'h30);
      do_done(1'b1);
      chk("R8 wrap downward", dst_addr, 24'hFFFFFE);
      @(negedge clk);
      addr_load = 1'b1; addr_din = 24'h000040; xfer_done = 1'b1;
      @(negedge clk);
      addr_load = 1'b0; xfer_done = 1'b0;
      chk("R8 load beats done", dst_addr, 24'h000040);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arming();
      t_nmi();
      t_standby();
      t_fields();
      t_addr();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule